// File: doc/BRIEF.md
# Windowed Branch Anomaly Detector

This block sits beside a processor pipeline and looks for bursts of suspicious control flow. Every cycle it receives a retired-instruction strobe and six branch-event strobes. A shared window counter measures an instruction window of programmable length. Two event counters each follow one selected branch event type inside that window. When a counter's total reaches its programmed threshold, the block records a hit. A detection event is then raised, either on any single hit or only when both enabled counters hit in the same window. The detection event drives a level interrupt.

Software programs the block through a small register port with four 64-bit registers: a global control word, a status word, and one configuration word per counter. The status word holds the detection flag, the hit flags, the window position and the counts. Software can read the status word and write it back, so monitoring of a task can be saved when the task is switched out and resumed later from the same point. Writing zero clears the detection and releases the interrupt. While a detection is pending, all status fields are frozen so that software sees the state that caused it.

Top module: `branch_anomaly_mon`

## Requirements
- R1: After reset, all four registers read as zero and `irq` is low.
- R2: Register addresses are 0 = control, 1 = status, 2 = counter 0 configuration and 3 = counter 1 configuration; reads are combinational from `reg_addr`. Control fields: unit enable in bits 1:0, window size in bits 17:8, both-counters mode in bit 26. Configuration fields: counter enable in bit 0, event select in bits 3:1, threshold in bits 14:8. Every other control and configuration bit reads as zero.
- R3: Status bits 25:16 hold the window position. It advances by one on each cycle with `retire_stb` high, but only while control bits 1:0 are both 1 and no detection is pending. With the unit disabled, no status field changes.
- R4: On the cycle after the window position has reached the window size, the window position, every count and every hit flag become zero, and the strobes of that cycle are not counted.
- R5: Count i sits in status bits 32+8i+7:32+8i. An enabled counter adds one on each cycle where `evt_stb[sel]` is high, with event select codes 0 to 5 naming strobe bits 0 to 5. Codes 6 and 7 count nothing.
- R6: A count saturates at 255.
- R7: Hit flag i (status bit 8+i) is set in the same cycle in which the enabled counter's count becomes greater than or equal to its threshold. The flag then stays set until the window rolls over or software writes the status word.
- R8: With bit 26 clear, any hit sets the detection flag (status bit 0), and `irq` equals that flag.
- R9: With bit 26 set, the detection flag is set only when every enabled counter has hit within the same window. A single hit leaves it clear.
- R10: While the detection flag is set, strobes change no status field. Writing zero to the status word clears the flag and lowers `irq`.
- R11: A status write loads the detection flag, the hit flags, the window position and the counts from the written value. Counting then continues from the loaded values.
- R12: A counter whose enable bit is clear keeps its count while the window keeps advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| retire_stb | input | 1 | One instruction retired this cycle |
| evt_stb | input | 6 | Branch event strobes: returns, call/return pairing, mispredicted returns, mispredicted branches, mispredicted indirect branches, far branches |
| irq | output | 1 | Level interrupt, high while a detection is pending |

## Verification
The assertions assume that the strobes are single-cycle qualified pulses sampled at the clock edge. They also assume that a status write in a cycle takes precedence over any strobe in the same cycle, so no property checks counting across a write. The stimulus changes inputs only on the falling clock edge and, before a rollover is observed, loads window positions no larger than the window size. This keeps every step of the window and counters to zero, one, or a clear. Saturation and the both-counters mode are reached by loading counts near their limits through the status word, not by long runs of strobes.

// File: rtl/brm_pkg.sv
package brm_pkg;
  localparam int REG_W    = 64;
  localparam int NUM_EVT  = 6;
  localparam int SEL_W    = 3;
  localparam int NUM_SLOT = 4;

  // register addresses
  localparam int CTRL_ADDR = 0;
  localparam int STAT_ADDR = 1;
  localparam int CFG_BASE  = 2;

  // control word fields
  localparam int CTRL_EN_LSB  = 0;
  localparam int CTRL_WIN_LSB = 8;
  localparam int CTRL_AND_BIT = 26;

  // counter configuration fields
  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_SEL_LSB = 1;
  localparam int CFG_THR_LSB = 8;

  // status word fields
  localparam int ST_EVT_BIT = 0;
  localparam int ST_HIT_LSB = 8;
  localparam int ST_WIN_LSB = 16;
  localparam int ST_CNT_LSB = 32;
endpackage

// File: rtl/brm_regs.sv
module brm_regs import brm_pkg::*; #(
  parameter int NUM_CNT = 2,
  parameter int WIN_W   = 10,
  parameter int THR_W   = 7,
  parameter int ADDR_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [REG_W-1:0]              wdata,
  output logic                          unit_on,
  output logic                          and_mode,
  output logic [WIN_W-1:0]              win_size,
  output logic [NUM_CNT-1:0]            cnt_en,
  output logic [NUM_CNT-1:0][SEL_W-1:0] cnt_sel,
  output logic [NUM_CNT-1:0][THR_W-1:0] cnt_thr,
  output logic [REG_W-1:0]              ctrl_word,
  output logic [NUM_CNT-1:0][REG_W-1:0] cfg_word
);
  logic             unused_wdata;
  logic             ctrl_we;
  logic [1:0]       en_q, en_d;
  logic             and_q, and_d;
  logic [WIN_W-1:0] size_q, size_d;

  assign unused_wdata = ^wdata;
  assign ctrl_we      = we && (addr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    en_d   = en_q;
    and_d  = and_q;
    size_d = size_q;
    if (ctrl_we) begin
      en_d   = wdata[CTRL_EN_LSB +: 2];
      and_d  = wdata[CTRL_AND_BIT];
      size_d = wdata[CTRL_WIN_LSB +: WIN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      and_q  <= 1'b0;
      size_q <= '0;
    end else if (ctrl_we) begin
      en_q   <= en_d;
      and_q  <= and_d;
      size_q <= size_d;
    end
  end

  assign unit_on  = &en_q;
  assign and_mode = and_q;
  assign win_size = size_q;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_EN_LSB +: 2]      = en_q;
    ctrl_word[CTRL_AND_BIT]          = and_q;
    ctrl_word[CTRL_WIN_LSB +: WIN_W] = size_q;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cfg
    logic             cfg_we;
    logic             en_q_i, en_d_i;
    logic [SEL_W-1:0] sel_q_i, sel_d_i;
    logic [THR_W-1:0] thr_q_i, thr_d_i;

    assign cfg_we = we && (addr == ADDR_W'(CFG_BASE + i));

    always_comb begin
      en_d_i  = en_q_i;
      sel_d_i = sel_q_i;
      thr_d_i = thr_q_i;
      if (cfg_we) begin
        en_d_i  = wdata[CFG_EN_BIT];
        sel_d_i = wdata[CFG_SEL_LSB +: SEL_W];
        thr_d_i = wdata[CFG_THR_LSB +: THR_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q_i  <= 1'b0;
        sel_q_i <= '0;
        thr_q_i <= '0;
      end else if (cfg_we) begin
        en_q_i  <= en_d_i;
        sel_q_i <= sel_d_i;
        thr_q_i <= thr_d_i;
      end
    end

    assign cnt_en[i]  = en_q_i;
    assign cnt_sel[i] = sel_q_i;
    assign cnt_thr[i] = thr_q_i;

    always_comb begin
      cfg_word[i] = '0;
      cfg_word[i][CFG_EN_BIT]              = en_q_i;
      cfg_word[i][CFG_SEL_LSB +: SEL_W]    = sel_q_i;
      cfg_word[i][CFG_THR_LSB +: THR_W]    = thr_q_i;
    end
  end
endmodule

// File: rtl/brm_window.sv
module brm_window #(
  parameter int WIN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIN_W-1:0] load_win,
  input  logic             run_ok,
  input  logic             retire,
  input  logic [WIN_W-1:0] size,
  output logic [WIN_W-1:0] win,
  output logic             roll
);
  logic [WIN_W-1:0] win_q, win_d;
  logic             step;

  assign roll = run_ok && (win_q >= size);
  assign step = run_ok && retire;

  always_comb begin
    win_d = win_q;
    if (load)      win_d = load_win;
    else if (roll) win_d = '0;
    else if (step) win_d = win_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     win_q <= '0;
    else if (load || roll || step)  win_q <= win_d;
  end

  assign win = win_q;

  // R3: the window moves by at most one instruction per cycle
  p_win_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (win_q == '0 || win_q == $past(win_q) || win_q == $past(win_q) + 1'b1));

  // R3: a stopped unit leaves the window where it is
  p_win_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !run_ok) |=> $stable(win_q));

  // R4: reaching the size starts a fresh window
  p_win_roll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && !load) |=> (win_q == '0));
endmodule

// File: rtl/brm_evt_counter.sv
module brm_evt_counter import brm_pkg::*; #(
  parameter int CNT_W = 8,
  parameter int THR_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_cnt,
  input  logic               load_hit,
  input  logic               run,
  input  logic               clr,
  input  logic               en,
  input  logic [SEL_W-1:0]   sel,
  input  logic [THR_W-1:0]   thr,
  input  logic [NUM_EVT-1:0] evt_stb,
  output logic [CNT_W-1:0]   cnt,
  output logic               hit,
  output logic               hit_next
);
  localparam int PAD_W = 1 << SEL_W;

  logic [PAD_W-1:0] evt_pad;
  logic             evt_sel;
  logic             bump;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit_q, hit_d;

  // codes beyond the last event land on zero padding
  assign evt_pad = PAD_W'(evt_stb);
  assign evt_sel = evt_pad[sel];
  assign bump    = run && en && evt_sel && (cnt_q != '1);

  always_comb begin
    cnt_d = cnt_q;
    hit_d = hit_q;
    if (load) begin
      cnt_d = load_cnt;
      hit_d = load_hit;
    end else if (clr) begin
      cnt_d = '0;
      hit_d = 1'b0;
    end else if (run) begin
      if (bump) cnt_d = cnt_q + 1'b1;
      if (en && (cnt_d >= CNT_W'(thr))) hit_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (load || clr || run) begin
      cnt_q <= cnt_d;
      hit_q <= hit_d;
    end
  end

  assign cnt      = cnt_q;
  assign hit      = hit_q;
  assign hit_next = hit_d;

  // R5: counting proceeds by single steps
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt_q == '0 || cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  // R6: a full counter never wraps
  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && !load && !clr) |=> (cnt_q == '1));

  // R7: a hit stays recorded for the rest of the window
  p_hit_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !load && !clr) |=> hit_q);

  // R12: a disabled counter keeps its value
  p_off_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/branch_anomaly_mon.sv
module branch_anomaly_mon import brm_pkg::*; #(
  parameter int NUM_CNT = 2,
  parameter int WIN_W   = 10,
  parameter int CNT_W   = 8,
  parameter int THR_W   = 7,
  localparam int ADDR_W = $clog2(CFG_BASE + NUM_CNT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               retire_stb,
  input  logic [NUM_EVT-1:0] evt_stb,
  output logic               irq
);
  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  logic                          unit_on, and_mode;
  logic [WIN_W-1:0]              win_size, win;
  logic [NUM_CNT-1:0]            cnt_en, hit, hit_next;
  logic [NUM_CNT-1:0][SEL_W-1:0] cnt_sel;
  logic [NUM_CNT-1:0][THR_W-1:0] cnt_thr;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [REG_W-1:0]              ctrl_word, status_word;
  logic [NUM_CNT-1:0][REG_W-1:0] cfg_word;
  logic                          stat_we, active, roll, run, clr;
  logic                          evt_q, evt_d, evt_eval;

  assign stat_we = reg_we && (reg_addr == ADDR_W'(STAT_ADDR));

  brm_regs #(
    .NUM_CNT(NUM_CNT), .WIN_W(WIN_W), .THR_W(THR_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .unit_on  (unit_on),
    .and_mode (and_mode),
    .win_size (win_size),
    .cnt_en   (cnt_en),
    .cnt_sel  (cnt_sel),
    .cnt_thr  (cnt_thr),
    .ctrl_word(ctrl_word),
    .cfg_word (cfg_word)
  );

  // a pending detection freezes all monitoring state
  assign active = unit_on && !evt_q;

  brm_window #(.WIN_W(WIN_W)) u_window (
    .clk     (clk),
    .rst_n   (rst_sync),
    .load    (stat_we),
    .load_win(reg_wdata[ST_WIN_LSB +: WIN_W]),
    .run_ok  (active),
    .retire  (retire_stb),
    .size    (win_size),
    .win     (win),
    .roll    (roll)
  );

  assign run = active && !roll;
  assign clr = roll;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    brm_evt_counter #(.CNT_W(CNT_W), .THR_W(THR_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_sync),
      .load    (stat_we),
      .load_cnt(reg_wdata[ST_CNT_LSB + i*CNT_W +: CNT_W]),
      .load_hit(reg_wdata[ST_HIT_LSB + i]),
      .run     (run),
      .clr     (clr),
      .en      (cnt_en[i]),
      .sel     (cnt_sel[i]),
      .thr     (cnt_thr[i]),
      .evt_stb (evt_stb),
      .cnt     (cnt[i]),
      .hit     (hit[i]),
      .hit_next(hit_next[i])
    );
  end

  // detection: any enabled hit, or all enabled counters in the both-counters mode
  always_comb begin
    if (and_mode) evt_eval = (|cnt_en) && ((hit_next & cnt_en) == cnt_en);
    else          evt_eval = |(hit_next & cnt_en);
  end

  always_comb begin
    evt_d = evt_q;
    if (stat_we)  evt_d = reg_wdata[ST_EVT_BIT];
    else if (run) evt_d = evt_eval;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync)            evt_q <= 1'b0;
    else if (stat_we || run)  evt_q <= evt_d;
  end

  assign irq = evt_q;

  always_comb begin
    status_word = '0;
    status_word[ST_EVT_BIT]          = evt_q;
    status_word[ST_WIN_LSB +: WIN_W] = win;
    for (int i = 0; i < NUM_CNT; i++) begin
      status_word[ST_HIT_LSB + i]                 = hit[i];
      status_word[ST_CNT_LSB + i*CNT_W +: CNT_W] = cnt[i];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CTRL_ADDR))      reg_rdata = ctrl_word;
    else if (reg_addr == ADDR_W'(STAT_ADDR)) reg_rdata = status_word;
    else begin
      for (int i = 0; i < NUM_CNT; i++)
        if (reg_addr == ADDR_W'(CFG_BASE + i)) reg_rdata = cfg_word[i];
    end
  end

  // R10: a pending detection holds every status field
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_sync)
    (irq && !stat_we) |=> $stable(status_word));

  // R3: a disabled unit holds every status field
  p_unit_off_r3: assert property (@(posedge clk) disable iff (!rst_sync)
    (!unit_on && !stat_we) |=> $stable(status_word));

  // R8: the interrupt only rises out of a hit or a status load
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_sync)
    ($rose(irq) && !$past(stat_we)) |-> (|hit));

  // R10: only a status write lowers the interrupt
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync)
    (irq && !stat_we) |=> irq);
endmodule

// File: tb/branch_anomaly_mon_tb.sv
module branch_anomaly_mon_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic        retire_stb;
  logic [5:0]  evt_stb;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_anomaly_mon u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .retire_stb(retire_stb),
    .evt_stb   (evt_stb),
    .irq       (irq)
  );

  function automatic logic [63:0] f_ctrl(int size, bit both);
    return (64'(both) << 26) | (64'(size) << 8) | 64'h3;
  endfunction

  function automatic logic [63:0] f_cfg(bit en, int sel, int thr);
    return (64'(thr) << 8) | (64'(sel) << 1) | 64'(en);
  endfunction

  function automatic logic [63:0] f_stat(bit ev, int hits, int win, int c0, int c1);
    return 64'(ev) | (64'(hits) << 8) | (64'(win) << 16) | (64'(c0) << 32) | (64'(c1) << 40);
  endfunction

  // all tasks begin just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic cyc(input logic r, input logic [5:0] e);
    retire_stb = r; evt_stb = e;
    @(negedge clk);
    retire_stb = 1'b0; evt_stb = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic chk_stat(input string req, input string what, input logic [63:0] exp);
    logic [63:0] v;
    rd(2'd1, v);
    chk(req, what, v, exp);
  endtask

  task automatic t_reset;
    logic [63:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1", $sformatf("register %0d after reset", a), v, 64'h0);
    end
    chk("R1", "irq after reset", 64'(irq), 64'h0);
  endtask

  task automatic t_regmap;
    logic [63:0] v;
    wr(2'd0, '1);
    rd(2'd0, v); chk("R2", "control readback mask", v, 64'h0403_FF03);
    wr(2'd2, '1);
    rd(2'd2, v); chk("R2", "config 0 readback mask", v, 64'h7F0F);
    wr(2'd3, f_cfg(1'b0, 4, 17));
    rd(2'd3, v); chk("R2", "config 1 fields", v, 64'h110_8);
    wr(2'd2, '0);
    wr(2'd3, '0);
    wr(2'd0, '0);
    chk_stat("R2", "status untouched by config writes", 64'h0);
  endtask

  task automatic t_window;
    wr(2'd0, f_ctrl(10, 1'b0));
    wr(2'd1, '0);
    for (int k = 0; k < 4; k++) cyc(1'b1, '0);
    chk_stat("R3", "window after four retires", f_stat(0, 0, 4, 0, 0));
    wr(2'd0, (64'd10 << 8) | 64'h1);
    for (int k = 0; k < 3; k++) cyc(1'b1, 6'h3F);
    chk_stat("R3", "half-enabled unit holds window", f_stat(0, 0, 4, 0, 0));
  endtask

  task automatic t_roll;
    wr(2'd0, f_ctrl(5, 1'b0));
    wr(2'd1, '0);
    wr(2'd2, f_cfg(1'b1, 3, 127));
    cyc(1'b1, 6'b001000);
    cyc(1'b1, 6'b001000);
    for (int k = 0; k < 3; k++) cyc(1'b1, '0);
    chk_stat("R4", "window at size before rollover", f_stat(0, 0, 5, 2, 0));
    cyc(1'b1, 6'b001000);
    chk_stat("R4", "rollover clears window and count, strobes dropped", 64'h0);
  endtask

  task automatic t_select;
    wr(2'd0, f_ctrl(1023, 1'b0));
    wr(2'd1, '0);
    wr(2'd2, f_cfg(1'b1, 5, 127));
    wr(2'd3, f_cfg(1'b1, 0, 127));
    cyc(1'b0, 6'b100001);
    chk_stat("R5", "codes 5 and 0 count their strobes", f_stat(0, 0, 0, 1, 1));
    cyc(1'b0, 6'b011110);
    chk_stat("R5", "other strobes ignored", f_stat(0, 0, 0, 1, 1));
    wr(2'd2, f_cfg(1'b1, 6, 127));
    cyc(1'b0, 6'b111111);
    chk_stat("R5", "code 6 counts nothing", f_stat(0, 0, 0, 1, 2));
  endtask

  task automatic t_both;
    wr(2'd0, f_ctrl(1023, 1'b1));
    wr(2'd2, f_cfg(1'b1, 3, 100));
    wr(2'd3, f_cfg(1'b1, 4, 127));
    wr(2'd1, f_stat(0, 0, 0, 253, 0));
    for (int k = 0; k < 4; k++) cyc(1'b0, 6'b001000);
    chk_stat("R6", "count saturates, single hit no event (R9)", f_stat(0, 1, 0, 255, 0));
    chk("R9", "irq low on one hit in both-counters mode", 64'(irq), 64'h0);
    wr(2'd1, f_stat(0, 1, 1023, 255, 0));
    @(negedge clk);
    chk_stat("R4", "rollover clears hit flag", 64'h0);
    wr(2'd1, f_stat(0, 1, 0, 255, 126));
    cyc(1'b0, 6'b010000);
    chk_stat("R9", "both counters hit sets event", f_stat(1, 3, 0, 255, 127));
    chk("R9", "irq high after both hits", 64'(irq), 64'h1);
  endtask

  task automatic t_freeze;
    for (int k = 0; k < 3; k++) cyc(1'b1, 6'h3F);
    chk_stat("R10", "status frozen while event pending", f_stat(1, 3, 0, 255, 127));
    chk("R10", "irq held", 64'(irq), 64'h1);
    wr(2'd1, '0);
    chk_stat("R10", "zero write clears status", 64'h0);
    chk("R10", "irq released", 64'(irq), 64'h0);
  endtask

  task automatic t_any;
    wr(2'd0, f_ctrl(1023, 1'b0));
    wr(2'd2, f_cfg(1'b1, 3, 3));
    wr(2'd3, f_cfg(1'b0, 4, 127));
    wr(2'd1, '0);
    cyc(1'b0, 6'b001000);
    cyc(1'b0, 6'b001000);
    chk_stat("R7", "below threshold no hit", f_stat(0, 0, 0, 2, 0));
    chk("R8", "irq low below threshold", 64'(irq), 64'h0);
    cyc(1'b0, 6'b001000);
    chk_stat("R7", "hit at threshold sets event (R8)", f_stat(1, 1, 0, 3, 0));
    chk("R8", "irq follows event flag", 64'(irq), 64'h1);
  endtask

  task automatic t_restore;
    wr(2'd2, f_cfg(1'b1, 3, 127));
    wr(2'd1, f_stat(0, 0, 7, 40, 0));
    chk("R11", "irq cleared by restore", 64'(irq), 64'h0);
    cyc(1'b1, 6'b001000);
    chk_stat("R11", "counting resumes from loaded values", f_stat(0, 0, 8, 41, 0));
  endtask

  task automatic t_disable;
    wr(2'd2, f_cfg(1'b0, 3, 127));
    cyc(1'b1, 6'b001000);
    chk_stat("R12", "disabled counter keeps count, window moves", f_stat(0, 0, 9, 41, 0));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    retire_stb = 1'b0; evt_stb = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_regmap;
    t_window;
    t_roll;
    t_select;
    t_both;
    t_freeze;
    t_any;
    t_restore;
    t_disable;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule